// File: doc/BRIEF.md
# Sprint thermal budget controller

This controller runs short bursts of parallel work in which the idle cores of a cluster are switched on together, well above the power the package can shed in steady state. A remaining thermal capacity is approximated by an energy accumulator. The accumulator is fed each clock tick by the activity counts of the cores that are powered. It is drained at the same time by the dissipation that one core could sustain. While a burst runs, the frequency level is held at its maximum.

A burst starts only from the idle state, on a parallel-work request. The extra cores are then brought up one at a time with a fixed spacing. This avoids a sudden current step on the supply. When the estimated energy nears the budget, the controller interrupts software and asks it to move the threads back to a single core. An acknowledge from software closes the burst in a fixed order: first the cores are collapsed to core 0, then the frequency drops to its minimum. If software is slow, or the full budget is reached first, hardware divides the frequency level by the core count and keeps it there until the acknowledge arrives. A cool-down whose length is proportional to the burst length then blocks any new burst.

All pins are plain control and status levels sampled every tick. The block has no streaming interface, so it has no back-pressure rules.

Top module: `sprint_budget_ctrl`

## Requirements
- R1: A burst begins (sprinting goes high on the next cycle) only when work_avail is high and the controller is idle; while cooling is high, work_avail has no effect; from idle with work_avail held high, sprinting rises one cycle after cooling falls.
- R2: After reset: core_en has only bit 0 set, freq_lvl equals FREQ_MIN, and migrate_req, sprinting, cooling and hw_throttled are low.
- R3: core_en bit i enables core i. On the cycle after a burst starts, core_en is binary 11. Core k (k at least 2) is enabled (k-1)*RAMP_GAP cycles later, and no cycle adds more than one core. Core 0 is always enabled.
- R4: On every tick, the accumulator adds ACT_WEIGHT times the count of each enabled core and subtracts SUSTAIN, and it saturates at zero. The count of core i is act_cnt bits [i*CNT_W +: CNT_W]. Counts of disabled cores are ignored.
- R5: During a burst, migrate_req rises on the cycle after the accumulator first holds a value at or above NEAR_LVL.
- R6: If no acknowledge arrives, freq_lvl becomes FREQ_MAX/NCORES exactly ACK_TIMEOUT cycles after migrate_req rose. hw_throttled is then set and stays set until reset. An acknowledge given before that point leaves hw_throttled low.
- R7: While migrate_req is waiting, an accumulator at or above BUDGET_LVL throttles freq_lvl to FREQ_MAX/NCORES on the next cycle, even before the timeout, and sets hw_throttled.
- R8: On the cycle after sw_ack is sampled high during a migrate request, core_en returns to bit 0 alone and migrate_req falls, while freq_lvl keeps its value. On the following cycle, freq_lvl equals FREQ_MIN and cooling is high.
- R9: cooling stays high for exactly COOL_MULT times the number of cycles that sprinting was high, and sprinting stays low throughout.
- R10: On the first cycle of a burst, freq_lvl equals FREQ_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| work_avail | input | 1 | Parallel work is waiting |
| act_cnt | input | NCORES*CNT_W | Per-core activity counts for this tick, core i in bits [i*CNT_W +: CNT_W] |
| sw_ack | input | 1 | Software reports threads moved to core 0 |
| core_en | output | NCORES | Per-core power enable |
| freq_lvl | output | FREQ_W | Selected frequency level |
| migrate_req | output | 1 | Interrupt asking software to migrate to one core |
| sprinting | output | 1 | Burst in progress |
| cooling | output | 1 | Cool-down in progress; bursts blocked |
| hw_throttled | output | 1 | Sticky: hardware forced the throttled level |

## Verification
The bench builds the block with 4 cores, 4-bit counts, weight 2, sustain 3, a near level of 200, a budget of 300, a timeout of 8, a ramp spacing of 3, a cool-down factor of 4 and a maximum level of 16. With these sizes, every nonzero per-core count from 1 to 15 can be swept, and the expected near-level crossing is computed by arithmetic for each one. The sweep reaches the timeout path for small counts and the budget path for larger ones. The whole ramp, and cool-down periods of a few hundred cycles, are measured exactly. A separate run applies activity only on a core that is still powered down, which shows that such counts are masked.

// File: rtl/sprint_pkg.sv
package sprint_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_RUN,
    ST_MIGR,
    ST_THRT,
    ST_SHUT,
    ST_COOL
  } spr_state_t;
endpackage

// File: rtl/spr_core_ramp.sv
module spr_core_ramp #(
  parameter int NCORES   = 16,
  parameter int RAMP_GAP = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              collapse,
  output logic [NCORES-1:0] core_en,
  output logic              all_on
);
  localparam int GAP_W = $clog2(RAMP_GAP + 1);

  logic [GAP_W-1:0] gap_cnt;

  assign all_on = &core_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_en <= NCORES'(1);
      gap_cnt <= '0;
    end else if (start) begin
      core_en <= NCORES'(3);
      gap_cnt <= '0;
    end else if (collapse) begin
      core_en <= NCORES'(1);
      gap_cnt <= '0;
    end else if (run && !all_on) begin
      if (gap_cnt == GAP_W'(RAMP_GAP - 1)) begin
        gap_cnt <= '0;
        core_en <= {core_en[NCORES-2:0], 1'b1};
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R3: at most one extra core per tick
  assert_one_core_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(core_en) <= $countones($past(core_en)) + 1);
  // R3: core 0 never drops
  assert_core0_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_en[0]);
endmodule

// File: rtl/spr_energy_acc.sv
module spr_energy_acc #(
  parameter int NCORES     = 16,
  parameter int CNT_W      = 8,
  parameter int ACT_WEIGHT = 1,
  parameter int SUSTAIN    = 16,
  parameter int ACC_W      = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCORES-1:0]       core_en,
  input  logic [NCORES*CNT_W-1:0] act_cnt,
  output logic [ACC_W-1:0]        acc
);
  localparam int TERM_W = CNT_W + $clog2(ACT_WEIGHT + 1);
  localparam int SUM_W  = TERM_W + $clog2(NCORES) + 1;
  localparam int EXT_W  = ACC_W + SUM_W;
  localparam logic [EXT_W-1:0] ACC_MAX = {{SUM_W{1'b0}}, {ACC_W{1'b1}}};
  localparam logic [EXT_W-1:0] DRAIN   = EXT_W'(SUSTAIN);

  logic [TERM_W-1:0] term [NCORES];
  logic [SUM_W-1:0]  act_sum;
  logic [EXT_W-1:0]  raised, drained;

  for (genvar i = 0; i < NCORES; i++) begin : g_term
    assign term[i] = core_en[i] ?
      TERM_W'(act_cnt[i*CNT_W +: CNT_W]) * TERM_W'(ACT_WEIGHT) : '0;
  end

  always_comb begin
    act_sum = '0;
    for (int i = 0; i < NCORES; i++) act_sum = act_sum + SUM_W'(term[i]);
    raised  = EXT_W'(acc) + EXT_W'(act_sum);
    drained = (raised > DRAIN) ? raised - DRAIN : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else if (drained > ACC_MAX) acc <= '1;
    else acc <= drained[ACC_W-1:0];
  end

  // R4: with no enabled activity the estimate can only fall or stay at zero
  assert_idle_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sum == '0) |=> (acc <= $past(acc)));
endmodule

// File: rtl/spr_cool_timer.sv
module spr_cool_timer #(
  parameter int LEN_W     = 24,
  parameter int COOL_MULT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count,
  input  logic load,
  input  logic dec,
  output logic done
);
  localparam int CC_W = LEN_W + $clog2(COOL_MULT + 1);

  logic [LEN_W-1:0] spr_len;
  logic [CC_W-1:0]  cool_cnt;

  assign done = (cool_cnt <= CC_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spr_len  <= '0;
      cool_cnt <= '0;
    end else begin
      if (clear) spr_len <= '0;
      else if (count && spr_len != '1) spr_len <= spr_len + 1'b1;
      if (load) cool_cnt <= CC_W'(spr_len) * CC_W'(COOL_MULT);
      else if (dec && cool_cnt != '0) cool_cnt <= cool_cnt - 1'b1;
    end
  end

  // R9: a loaded cool-down is never empty
  assert_cool_loaded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cool_cnt != '0));
endmodule

// File: rtl/sprint_budget_ctrl.sv
module sprint_budget_ctrl
  import sprint_pkg::*;
#(
  parameter int NCORES      = 16,
  parameter int CNT_W       = 8,
  parameter int ACT_WEIGHT  = 1,
  parameter int SUSTAIN     = 16,
  parameter int ACC_W       = 24,
  parameter int NEAR_LVL    = 900000,
  parameter int BUDGET_LVL  = 1000000,
  parameter int ACK_TIMEOUT = 1000,
  parameter int RAMP_GAP    = 625,
  parameter int COOL_MULT   = 16,
  parameter int LEN_W       = 24,
  parameter int FREQ_W      = 6,
  parameter int FREQ_MAX    = 32,
  parameter int FREQ_MIN    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    work_avail,
  input  logic [NCORES*CNT_W-1:0] act_cnt,
  input  logic                    sw_ack,
  output logic [NCORES-1:0]       core_en,
  output logic [FREQ_W-1:0]       freq_lvl,
  output logic                    migrate_req,
  output logic                    sprinting,
  output logic                    cooling,
  output logic                    hw_throttled
);
  localparam int TMO_W   = $clog2(ACK_TIMEOUT + 1);
  localparam int THR_LVL = FREQ_MAX / NCORES;

  spr_state_t       st;
  logic [ACC_W-1:0] acc;
  logic [TMO_W-1:0] tmo_cnt;
  logic             all_on, cool_done, start, collapse, near, over;

  assign sprinting = (st == ST_RAMP) || (st == ST_RUN) ||
                     (st == ST_MIGR) || (st == ST_THRT);
  assign cooling   = (st == ST_COOL);
  assign start     = (st == ST_IDLE) && work_avail;
  assign collapse  = ((st == ST_MIGR) || (st == ST_THRT)) && sw_ack;
  assign near      = acc >= ACC_W'(NEAR_LVL);
  assign over      = acc >= ACC_W'(BUDGET_LVL);

  spr_core_ramp #(.NCORES(NCORES), .RAMP_GAP(RAMP_GAP)) u_ramp (
    .clk(clk), .rst_n(rst_n), .start(start), .run(st == ST_RAMP),
    .collapse(collapse), .core_en(core_en), .all_on(all_on)
  );

  spr_energy_acc #(.NCORES(NCORES), .CNT_W(CNT_W), .ACT_WEIGHT(ACT_WEIGHT),
                   .SUSTAIN(SUSTAIN), .ACC_W(ACC_W)) u_energy (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .act_cnt(act_cnt), .acc(acc)
  );

  spr_cool_timer #(.LEN_W(LEN_W), .COOL_MULT(COOL_MULT)) u_cool (
    .clk(clk), .rst_n(rst_n), .clear(start), .count(sprinting),
    .load(st == ST_SHUT), .dec(st == ST_COOL), .done(cool_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      freq_lvl     <= FREQ_W'(FREQ_MIN);
      migrate_req  <= 1'b0;
      hw_throttled <= 1'b0;
      tmo_cnt      <= '0;
    end else begin
      case (st)
        ST_IDLE: if (work_avail) begin
          st       <= ST_RAMP;
          freq_lvl <= FREQ_W'(FREQ_MAX);
        end
        ST_RAMP, ST_RUN: begin
          if (over) begin
            st           <= ST_THRT;
            migrate_req  <= 1'b1;
            freq_lvl     <= FREQ_W'(THR_LVL);
            hw_throttled <= 1'b1;
          end else if (near) begin
            st          <= ST_MIGR;
            migrate_req <= 1'b1;
            tmo_cnt     <= '0;
          end else if (st == ST_RAMP && all_on) begin
            st <= ST_RUN;
          end
        end
        ST_MIGR: begin
          if (sw_ack) begin
            st          <= ST_SHUT;
            migrate_req <= 1'b0;
          end else if (over || tmo_cnt == TMO_W'(ACK_TIMEOUT - 1)) begin
            st           <= ST_THRT;
            freq_lvl     <= FREQ_W'(THR_LVL);
            hw_throttled <= 1'b1;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        ST_THRT: if (sw_ack) begin
          st          <= ST_SHUT;
          migrate_req <= 1'b0;
        end
        ST_SHUT: begin
          freq_lvl <= FREQ_W'(FREQ_MIN);
          st       <= ST_COOL;
        end
        ST_COOL: if (cool_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: a burst only opens from idle on a work request
  assert_start_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sprinting) |-> ($past(st) == ST_IDLE && $past(work_avail)));
  // R9: cool-down never hands over directly to a burst
  assert_cool_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COOL) |=> !sprinting);
  // R6: throttled state runs at max divided by core count
  assert_throttle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_THRT) |-> (freq_lvl == FREQ_W'(THR_LVL)));
  // R6: the throttle record is sticky
  assert_throttle_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hw_throttled) |-> hw_throttled);
  // R8: cores collapse before the frequency drops
  assert_cores_before_freq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHUT) |-> (core_en == NCORES'(1) && freq_lvl != FREQ_W'(FREQ_MIN)));
  assert_freq_after_cores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHUT) |=> (freq_lvl == FREQ_W'(FREQ_MIN)));
  // R5: migrate interrupt only inside a burst
  assert_migrate_in_sprint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    migrate_req |-> sprinting);
endmodule

// File: tb/sim_sprint_budget_ctrl.sv
module sim_sprint_budget_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NC   = 4;
  localparam int CW   = 4;
  localparam int WT   = 2;
  localparam int SUS  = 3;
  localparam int NEAR = 200;
  localparam int BUD  = 300;
  localparam int TMO  = 8;
  localparam int GAP  = 3;
  localparam int CM   = 4;
  localparam int FW   = 5;
  localparam int FMAX = 16;
  localparam int FMIN = 1;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, work_avail, sw_ack;
  logic [NC*CW-1:0] act_cnt;
  logic [NC-1:0] core_en;
  logic [FW-1:0] freq_lvl;
  logic migrate_req, sprinting, cooling, hw_throttled;

  sprint_budget_ctrl #(
    .NCORES(NC), .CNT_W(CW), .ACT_WEIGHT(WT), .SUSTAIN(SUS), .ACC_W(16),
    .NEAR_LVL(NEAR), .BUDGET_LVL(BUD), .ACK_TIMEOUT(TMO), .RAMP_GAP(GAP),
    .COOL_MULT(CM), .LEN_W(12), .FREQ_W(FW), .FREQ_MAX(FMAX), .FREQ_MIN(FMIN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .work_avail(work_avail), .act_cnt(act_cnt),
    .sw_ack(sw_ack), .core_en(core_en), .freq_lvl(freq_lvl),
    .migrate_req(migrate_req), .sprinting(sprinting), .cooling(cooling),
    .hw_throttled(hw_throttled)
  );

  int nchk = 0, nfail = 0;
  int spr_n = 0, cool_n = 0;
  bit finished = 0;

  task automatic check(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    if (sprinting) spr_n++;
    if (cooling) cool_n++;
  endtask

  task automatic set_all(input int a);
    for (int i = 0; i < NC; i++) act_cnt[i*CW +: CW] = CW'(a);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; work_avail = 1'b0; sw_ack = 1'b0; act_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 core_en", int'(core_en), 1);
    check("R2 freq", int'(freq_lvl), FMIN);
    check("R2 migrate", int'(migrate_req), 0);
    check("R2 sprinting", int'(sprinting), 0);
    check("R2 cooling", int'(cooling), 0);
    check("R2 throttled", int'(hw_throttled), 0);
  endtask

  task automatic run_sprint(input int a);
    int d, n, c, j, fnow;
    bit early, bud_hit, thr_exp, saw;
    do_reset;
    d = NC * a * WT - SUS;
    n = (NEAR + d - 1) / d;
    early = (a % 3 == 0);
    work_avail = 1'b1;
    spr_n = 0; cool_n = 0;
    step;
    for (int k = 0; k <= 8; k++) begin
      int e;
      if (k > 0) step;
      e = 2 + k / GAP;
      if (e > NC) e = NC;
      check("R3 ramp cores", $countones(core_en), e);
      if (k == 0) begin
        check("R1 sprint start", int'(sprinting), 1);
        check("R10 freq max", int'(freq_lvl), FMAX);
      end
    end
    set_all(a);
    c = 8;
    do begin step; c++; end while (!migrate_req && c < 400);
    check("R5 migrate cycle", c, 9 + n);
    if (early) begin
      thr_exp = 0;
      fnow = FMAX;
      sw_ack = 1'b1;
    end else begin
      j = 1;
      while (j < TMO && (n + j) * d < BUD) j++;
      bud_hit = ((n + j) * d >= BUD);
      for (int k = 1; k <= j; k++) begin
        step;
        if (k == j - 1) check("R6 not yet throttled", int'(freq_lvl), FMAX);
      end
      if (bud_hit) begin
        check("R7 budget throttle", int'(freq_lvl), FMAX / NC);
        check("R7 throttled flag", int'(hw_throttled), 1);
      end else begin
        check("R6 timeout throttle", int'(freq_lvl), FMAX / NC);
        check("R6 throttled flag", int'(hw_throttled), 1);
      end
      thr_exp = 1;
      fnow = FMAX / NC;
      sw_ack = 1'b1;
    end
    step;
    sw_ack = 1'b0;
    check("R8 cores collapsed", int'(core_en), 1);
    check("R8 migrate dropped", int'(migrate_req), 0);
    check("R8 freq held", int'(freq_lvl), fnow);
    set_all(0);
    step;
    check("R8 freq min", int'(freq_lvl), FMIN);
    check("R9 cooling on", int'(cooling), 1);
    saw = 0; c = 0;
    while (cooling && c < 5000) begin
      if (sprinting) saw = 1;
      step;
      c++;
    end
    check("R9 cool length", cool_n, CM * spr_n);
    check("R9 no sprint while cooling", int'(saw), 0);
    check("R1 idle after cool", int'(sprinting), 0);
    check("R6 sticky flag", int'(hw_throttled), int'(thr_exp));
    step;
    check("R1 restart from idle", int'(sprinting), 1);
    work_avail = 1'b0;
  endtask

  initial begin
    int c;
    do_reset;
    repeat (6) step;
    check("R1 no request stays idle", int'(sprinting), 0);
    check("R1 idle core_en", int'(core_en), 1);

    for (int a = 1; a <= 15; a++) run_sprint(a);

    // R4: counts on a core that is still off are masked
    do_reset;
    act_cnt[3*CW +: CW] = CW'(15);
    work_avail = 1'b1;
    step;
    c = 0;
    while (!migrate_req && c < 100) begin step; c++; end
    check("R4 masked core counts", c, 15);
    sw_ack = 1'b1;
    step;
    sw_ack = 1'b0;
    work_avail = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    finished = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog (all): got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule